// File: doc/BRIEF.md
# SDRAM command protocol checker

This block is a passive monitor for the command bus between a memory controller and a four-bank single-data-rate SDRAM. On every rising clock edge it samples the clock-enable, chip-select, the three command strobes, the bank address and address bit 10. It decodes the command and keeps a small state record for each bank: whether a row is open, clocks since the last activate and since the last precharge, and whether an auto-precharge burst is still running. It also keeps global ages for the last mode-register write, the last refresh and the last activate.

Each command is checked against the bank-state rules and the minimum-delay rules. All delays are parameters in whole clocks. The first rule break sets a sticky error flag and stores a violation code and the value of a free-running cycle counter. These stay until a synchronous clear or a reset. The block drives nothing onto the bus and is meant for simulation harnesses or on-chip debug next to a controller.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cs_n high (deselect), or cs_n low with strobes {ras_n,cas_n,we_n}=111 (NOP), no rule is checked and no error is raised. With cs_n low the strobes decode as 000 mode-register write, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop and 010 precharge.
- R2: A command is ignored, with no check and no state change, when cke was low at the previous clock edge.
- R3: A read, a write or a single-bank precharge to a bank with no open row gives code 6. An activate to a bank that already has an open row gives code 7. Bank state follows every decoded command, legal or not.
- R4: A precharge with a10 high closes all banks and ignores ba. A precharge with a10 low closes only bank ba (00 to 11 select banks 0 to 3). Banks that are already idle are not flagged by the all-banks form.
- R5: A mode-register write while any row is open gives code 3. Any command other than NOP or deselect fewer than T_MRD clocks after a mode-register write gives code 1.
- R6: A refresh while any row is open gives code 4. Any command other than NOP or deselect fewer than T_RFC clocks after a refresh gives code 2.
- R7: A read or write fewer than T_RCD clocks after the activate of its bank gives code 8.
- R8: An activate fewer than T_RP clocks after that bank was closed gives code 9. A bank is closed either by a precharge of its open row or by the last cycle of its auto-precharge burst.
- R9: An activate fewer than T_RRD clocks after any earlier activate gives code 10.
- R10: A precharge that closes a row opened fewer than T_RAS clocks earlier gives code 11.
- R11: A read or write with a10 high starts an auto-precharge burst. The burst covers the command cycle and the next BURST_LEN-1 cycles. Any read or write during the later cycles of the burst gives code 5. After the burst's last cycle the bank is idle.
- R12: When one command breaks several rules, the lowest code is reported. err_flag rises at the edge that samples the first violation, and err_code and err_cycle hold that violation's code and cycle number. The cycle number counts edges since reset, starting at 0. Later violations do not change these outputs.
- R13: clr high clears err_flag, err_code and err_cycle at the next edge and takes precedence over a violation in the same cycle.
- R14: Reset clears err_flag, err_code and err_cycle and marks all banks idle with every age saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the error record |
| cke | input | 1 | Sampled clock enable |
| cs_n | input | 1 | Sampled chip select, active low |
| ras_n | input | 1 | Sampled row strobe, active low |
| cas_n | input | 1 | Sampled column strobe, active low |
| we_n | input | 1 | Sampled write strobe, active low |
| ba | input | BA_W | Sampled bank address |
| a10 | input | 1 | Sampled address bit 10 (all-banks / auto-precharge) |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation |
| err_cycle | output | CYC_W | Cycle number of the first violation |

## Verification
The properties assume that cke is held at a known level during reset, because the clock-enable history register has no reset. They also assume that all bus inputs are free of unknown values after reset is released. BURST_LEN is taken to be at least 2, so that an auto-precharge burst always has a final cycle that closes the bank. The stimulus drives only defined levels on every input, keeps cke high while reset is asserted, and uses the default burst length. It changes inputs two nanoseconds after each rising edge, well clear of the next one.

// File: rtl/sdmon_pkg.sv
`timescale 1ns/1ps
package sdmon_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_MRS, C_REF, C_ACT, C_RD, C_WR, C_BST, C_PRE
  } cmd_e;

  // violation codes; a lower value wins when several apply
  localparam logic [3:0] V_NONE     = 4'd0;
  localparam logic [3:0] V_MRD      = 4'd1;
  localparam logic [3:0] V_RFC      = 4'd2;
  localparam logic [3:0] V_MRS_OPEN = 4'd3;
  localparam logic [3:0] V_REF_OPEN = 4'd4;
  localparam logic [3:0] V_AP_BUSY  = 4'd5;
  localparam logic [3:0] V_IDLE     = 4'd6;
  localparam logic [3:0] V_ACT_OPEN = 4'd7;
  localparam logic [3:0] V_RCD      = 4'd8;
  localparam logic [3:0] V_RP       = 4'd9;
  localparam logic [3:0] V_RRD      = 4'd10;
  localparam logic [3:0] V_RAS      = 4'd11;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdmon_decode.sv
`timescale 1ns/1ps
module sdmon_decode
  import sdmon_pkg::*;
(
  input  logic en,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = C_NOP;
    if (en && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = C_MRS;
        3'b001:  cmd = C_REF;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        default: cmd = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdmon_age.sv
`timescale 1ns/1ps
module sdmon_age #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [W-1:0] age
);

  // clocks since the last start, saturating at all ones
  always_ff @(posedge clk) begin
    if (rst)               age <= '1;
    else if (start)        age <= W'(1);
    else if (age != '1)    age <= age + W'(1);
  end

endmodule

// File: rtl/sdmon_bank.sv
`timescale 1ns/1ps
module sdmon_bank #(
  parameter int AGE_W     = 4,
  parameter int BURST_LEN = 4,
  parameter int LEFT_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             ap_i,
  output logic             open_o,
  output logic             ap_run_o,
  output logic [AGE_W-1:0] act_age_o,
  output logic [AGE_W-1:0] pre_age_o
);

  logic [LEFT_W-1:0] left_q;
  logic              open_q;
  logic              ap_close;
  logic              close_evt;

  assign ap_close  = (left_q == LEFT_W'(1));
  assign close_evt = (pre_i && open_q) || ap_close;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      left_q <= '0;
    end else begin
      if (act_i)          open_q <= 1'b1;
      else if (close_evt) open_q <= 1'b0;

      if (ap_i)                left_q <= LEFT_W'(BURST_LEN - 1);
      else if (left_q != '0)   left_q <= left_q - LEFT_W'(1);
    end
  end

  sdmon_age #(.W(AGE_W)) u_act_age (
    .clk(clk), .rst(rst), .start(act_i), .age(act_age_o)
  );

  sdmon_age #(.W(AGE_W)) u_pre_age (
    .clk(clk), .rst(rst), .start(close_evt), .age(pre_age_o)
  );

  assign open_o   = open_q;
  assign ap_run_o = (left_q != '0);

endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
  import sdmon_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RFC     = 8,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4,
  parameter int CYC_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  output logic             err_flag,
  output logic [3:0]       err_code,
  output logic [CYC_W-1:0] err_cycle
);

  localparam int NB     = 1 << BA_W;
  localparam int T_MAX  = imax(imax(imax(T_RCD, T_RP), imax(T_RRD, T_RAS)),
                               imax(T_RFC, T_MRD));
  localparam int AGE_W  = $clog2(T_MAX + 1) + 1;
  localparam int LEFT_W = $clog2(BURST_LEN) + 1;

  localparam logic [AGE_W-1:0] L_RCD = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0] L_RP  = AGE_W'(T_RP);
  localparam logic [AGE_W-1:0] L_RRD = AGE_W'(T_RRD);
  localparam logic [AGE_W-1:0] L_RAS = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] L_RFC = AGE_W'(T_RFC);
  localparam logic [AGE_W-1:0] L_MRD = AGE_W'(T_MRD);

  // clock-enable history: a command counts only if cke was high one edge earlier
  logic cke_q;
  always_ff @(posedge clk) cke_q <= cke;

  cmd_e cmd;
  sdmon_decode u_dec (
    .en(cke_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  logic is_cmd, is_rw;
  assign is_cmd = (cmd != C_NOP);
  assign is_rw  = (cmd == C_RD) || (cmd == C_WR);

  logic [NB-1:0]    act_hit, pre_hit, ap_hit, bank_open, ap_run, ras_short;
  logic [AGE_W-1:0] act_age [NB];
  logic [AGE_W-1:0] pre_age [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic sel;
    assign sel        = (ba == BA_W'(g));
    assign act_hit[g] = (cmd == C_ACT) && sel;
    assign pre_hit[g] = (cmd == C_PRE) && (a10 || sel);
    assign ap_hit[g]  = is_rw && a10 && sel;

    sdmon_bank #(.AGE_W(AGE_W), .BURST_LEN(BURST_LEN), .LEFT_W(LEFT_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .act_i    (act_hit[g]),
      .pre_i    (pre_hit[g]),
      .ap_i     (ap_hit[g]),
      .open_o   (bank_open[g]),
      .ap_run_o (ap_run[g]),
      .act_age_o(act_age[g]),
      .pre_age_o(pre_age[g])
    );

    assign ras_short[g] = pre_hit[g] && bank_open[g] && (act_age[g] < L_RAS);
  end

  logic [AGE_W-1:0] mrs_age, ref_age, any_act_age;

  sdmon_age #(.W(AGE_W)) u_mrs_age (
    .clk(clk), .rst(rst), .start(cmd == C_MRS), .age(mrs_age)
  );
  sdmon_age #(.W(AGE_W)) u_ref_age (
    .clk(clk), .rst(rst), .start(cmd == C_REF), .age(ref_age)
  );
  sdmon_age #(.W(AGE_W)) u_act_any (
    .clk(clk), .rst(rst), .start(cmd == C_ACT), .age(any_act_age)
  );

  // rule evaluation, highest priority first
  logic [3:0] viol;
  always_comb begin
    viol = V_NONE;
    if (is_cmd && (mrs_age < L_MRD))                             viol = V_MRD;
    else if (is_cmd && (ref_age < L_RFC))                        viol = V_RFC;
    else if ((cmd == C_MRS) && (|bank_open))                     viol = V_MRS_OPEN;
    else if ((cmd == C_REF) && (|bank_open))                     viol = V_REF_OPEN;
    else if (is_rw && (|ap_run))                                 viol = V_AP_BUSY;
    else if ((is_rw || ((cmd == C_PRE) && !a10)) && !bank_open[ba]) viol = V_IDLE;
    else if ((cmd == C_ACT) && bank_open[ba])                    viol = V_ACT_OPEN;
    else if (is_rw && (act_age[ba] < L_RCD))                     viol = V_RCD;
    else if ((cmd == C_ACT) && (pre_age[ba] < L_RP))             viol = V_RP;
    else if ((cmd == C_ACT) && (any_act_age < L_RRD))            viol = V_RRD;
    else if (|ras_short)                                         viol = V_RAS;
  end

  // free-running cycle count and first-error record
  logic [CYC_W-1:0] cyc_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q     <= '0;
      err_flag  <= 1'b0;
      err_code  <= V_NONE;
      err_cycle <= '0;
    end else begin
      cyc_q <= cyc_q + CYC_W'(1);
      if (clr) begin
        err_flag  <= 1'b0;
        err_code  <= V_NONE;
        err_cycle <= '0;
      end else if (!err_flag && (viol != V_NONE)) begin
        err_flag  <= 1'b1;
        err_code  <= viol;
        err_cycle <= cyc_q;
      end
    end
  end

endmodule

// File: rtl/sdmon_checker.sv
`timescale 1ns/1ps
module sdmon_checker #(
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             cke,
  input logic             cs_n,
  input logic             err_flag,
  input logic [3:0]       err_code,
  input logic [CYC_W-1:0] err_cycle
);

  // deselect never raises the flag
  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !err_flag && !clr) |=> !err_flag);

  // a command following a low cke sample is ignored
  p_cke_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(cke) && !err_flag && !clr) |=> !err_flag);

  // a raised flag always carries a code
  p_flag_has_code_r12: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (err_code != 4'd0));

  // the first record is held until cleared
  p_record_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr) |=> (err_flag && $stable(err_code) && $stable(err_cycle)));

  // clear wins over anything in the same cycle
  p_clear_wins_r13: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!err_flag && err_code == 4'd0));

  // reset empties the record
  p_reset_empty_r14: assert property (@(posedge clk)
    rst |=> (!err_flag && err_code == 4'd0 && err_cycle == '0));

endmodule

bind sdram_cmd_monitor sdmon_checker #(.CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .cke(cke), .cs_n(cs_n),
  .err_flag(err_flag), .err_code(err_code), .err_cycle(err_cycle)
);

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb;

  localparam int CYC_W = 16;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] DES = 4'b1111;
  localparam logic [3:0] MRS = 4'b0000;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] ACT = 4'b0011;
  localparam logic [3:0] RD  = 4'b0101;
  localparam logic [3:0] WR  = 4'b0100;
  localparam logic [3:0] BST = 4'b0110;
  localparam logic [3:0] PRE = 4'b0010;

  // vector: {cke, cmd[3:0], ba[1:0], a10, clr, expected code[3:0]}
  localparam int NV = 50;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 0  R1
    {1'b1, ACT, 2'd0, 1'b0, 1'b0, 4'd0},  // 1
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 2
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 3
    {1'b1, RD,  2'd0, 1'b0, 1'b0, 4'd0},  // 4  R7 boundary legal
    {1'b1, ACT, 2'd1, 1'b0, 1'b0, 4'd0},  // 5
    {1'b1, RD,  2'd1, 1'b0, 1'b0, 4'd8},  // 6  R7
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 7  R13
    {1'b1, PRE, 2'd0, 1'b0, 1'b0, 4'd0},  // 8  R4 single
    {1'b1, ACT, 2'd0, 1'b0, 1'b0, 4'd9},  // 9  R8
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 10
    {1'b1, ACT, 2'd2, 1'b0, 1'b0, 4'd0},  // 11 R9 boundary legal
    {1'b1, ACT, 2'd3, 1'b0, 1'b0, 4'd10}, // 12 R9
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 13
    {1'b1, PRE, 2'd1, 1'b0, 1'b0, 4'd0},  // 14
    {1'b1, PRE, 2'd2, 1'b0, 1'b0, 4'd11}, // 15 R10
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 16
    {1'b1, RD,  2'd1, 1'b0, 1'b0, 4'd6},  // 17 R3 idle access
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 18
    {1'b1, ACT, 2'd3, 1'b0, 1'b0, 4'd7},  // 19 R3 open bank
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 20
    {1'b1, MRS, 2'd0, 1'b0, 1'b0, 4'd3},  // 21 R5 rows open
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 22
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 23
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 24
    {1'b1, PRE, 2'd2, 1'b1, 1'b0, 4'd0},  // 25 R4 all banks, ba ignored
    {1'b1, REF, 2'd0, 1'b0, 1'b0, 4'd0},  // 26 R6 legal
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 27
    {1'b1, ACT, 2'd0, 1'b0, 1'b0, 4'd2},  // 28 R6 window
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 29
    {1'b1, DES, 2'd0, 1'b0, 1'b0, 4'd0},  // 30 R1 deselect inside window
    {1'b1, DES, 2'd3, 1'b1, 1'b0, 4'd0},  // 31 R1
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 32
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 33
    {1'b1, MRS, 2'd0, 1'b0, 1'b0, 4'd3},  // 34 R5 / R12 refresh window just ended
    {1'b1, BST, 2'd0, 1'b0, 1'b1, 4'd0},  // 35 R13 clear beats R5 window
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 36
    {1'b0, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 37 cke low
    {1'b1, RD,  2'd2, 1'b0, 1'b0, 4'd0},  // 38 R2 gated
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 39
    {1'b1, WR,  2'd0, 1'b1, 1'b0, 4'd0},  // 40 R11 auto-precharge write
    {1'b1, RD,  2'd0, 1'b0, 1'b0, 4'd5},  // 41 R11
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 42
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 43 last burst cycle
    {1'b1, RD,  2'd0, 1'b0, 1'b0, 4'd6},  // 44 R11 bank closed
    {1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0},  // 45
    {1'b1, ACT, 2'd0, 1'b0, 1'b0, 4'd0},  // 46 R8 boundary after burst
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0},  // 47
    {1'b1, ACT, 2'd3, 1'b0, 1'b0, 4'd0},  // 48 R4 bank 3 closed by all-banks precharge
    {1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0}   // 49
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clr = 1'b0;
  logic             cke = 1'b1;
  logic             cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]       ba = 2'd0;
  logic             a10 = 1'b0;
  logic             err_flag;
  logic [3:0]       err_code;
  logic [CYC_W-1:0] err_cycle;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(.CYC_W(CYC_W)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .err_flag(err_flag), .err_code(err_code), .err_cycle(err_cycle)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic setv(input logic [12:0] v);
    cke = v[12];
    {cs_n, ras_n, cas_n, we_n} = v[11:8];
    ba  = v[7:6];
    a10 = v[5];
    clr = v[4];
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    setv({1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0});
    repeat (3) step();
    chk("R14 flag after reset", int'(err_flag), 0);
    chk("R14 code after reset", int'(err_code), 0);
    chk("R14 cycle after reset", int'(err_cycle), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      setv(VEC[i]);
      step();
      chk($sformatf("R12 flag vec %0d", i), int'(err_flag), int'(VEC[i][3:0] != 4'd0));
      chk($sformatf("R12 code vec %0d", i), int'(err_code), int'(VEC[i][3:0]));
      if (VEC[i][3:0] != 4'd0)
        chk($sformatf("R12 cycle vec %0d", i), int'(err_cycle), i);
    end

    // R14: reset clears a latched error
    setv({1'b1, RD, 2'd2, 1'b0, 1'b0, 4'd0});
    step();
    chk("R3 idle read before reset", int'(err_code), 6);
    rst = 1'b1;
    setv({1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0});
    step();
    chk("R14 flag cleared by reset", int'(err_flag), 0);
    chk("R14 code cleared by reset", int'(err_code), 0);
    rst = 1'b0;

    // R12: first violation is kept, later ones are not recorded
    step();                                              // cycle 0
    setv({1'b1, RD,  2'd2, 1'b0, 1'b0, 4'd0}); step();  // cycle 1, idle bank
    chk("R12 first code", int'(err_code), 6);
    chk("R12 first cycle", int'(err_cycle), 1);
    setv({1'b1, ACT, 2'd0, 1'b0, 1'b0, 4'd0}); step();  // cycle 2
    setv({1'b1, ACT, 2'd1, 1'b0, 1'b0, 4'd0}); step();  // cycle 3, short gap
    chk("R12 sticky code", int'(err_code), 6);
    chk("R12 sticky cycle", int'(err_cycle), 1);
    setv({1'b1, NOP, 2'd0, 1'b0, 1'b1, 4'd0}); step();
    chk("R13 clear", int'(err_flag), 0);
    setv({1'b1, NOP, 2'd0, 1'b0, 1'b0, 4'd0}); step();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule